// File: doc/BRIEF.md
# Parallel Host Port with Nibble Mode

This block is the host-facing bus slave of a character-display controller. A microcontroller drives a strobe line, a register-select line and a direction line, plus eight data lines. The block turns each bus cycle into internal events. Each completed instruction write or data write becomes a one-cycle strobe that carries the assembled byte. Each completed data-register read becomes a one-cycle read strobe. Reads are answered from two sources: a status byte, made of a busy flag and a seven-bit address counter, and a data byte supplied by the rest of the controller.

The bus runs either eight bits wide, with one byte per strobe cycle, or four bits wide, using only the upper four data lines. In the narrow mode, every byte takes two strobe cycles, high nibble first. This applies to writes, data reads and status reads alike. The width is selected over the bus itself by a function-set instruction. The strobe is synchronised to the system clock, and write data is taken when the strobe falls.

Top module: `lcd_host_port`

## Requirements
- R1: After reset the port is in 8-bit mode (`wide_mode`=1), no internal strobe is active and `bus_d_oe` is 0.
- R2: In 8-bit mode each strobe high-to-low transition with `bus_rd`=0 gives exactly one write strobe carrying `bus_d_in[7:0]`: `cmd_wr` when `bus_sel`=0, `dat_wr` when `bus_sel`=1.
- R3: In 8-bit mode, while the strobe is high with `bus_rd`=1, `bus_d_out` is `{busy_flag, addr_cnt}` for `bus_sel`=0 and `rd_byte` for `bus_sel`=1, and `bus_d_oe` is 1.
- R4: In 4-bit mode a write takes two strobe cycles. The first supplies bits 7..4 on `bus_d_in[7:4]` and the second supplies bits 3..0 on `bus_d_in[7:4]`. A single write strobe is issued only after the second cycle.
- R5: In 4-bit mode the values on `bus_d_in[3:0]` have no effect on the assembled byte.
- R6: In 4-bit mode a status read takes two strobe cycles, both on `bus_d_out[7:4]`. The first returns `{busy_flag, addr_cnt[6:4]}` and the second returns `addr_cnt[3:0]`.
- R7: An instruction write whose bits 7..5 are 001 sets the width from bit 4 (1 = 8-bit, 0 = 4-bit), and the new width applies from the next strobe cycle with the nibble phase at the first half.
- R8: `dat_rd` pulses once per completed data-register read: once per strobe cycle in 8-bit mode, and only after the second nibble in 4-bit mode.
- R9: An instruction whose bits 7..5 are not 001, or a data write of any value, leaves the width unchanged.
- R10: `bus_d_oe` is 0 whenever `bus_rd`=0 or the synchronised strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_strobe | input | 1 | Asynchronous transfer strobe from the host |
| bus_sel | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_rd | input | 1 | Direction: 1 read, 0 write |
| bus_d_in | input | 8 | Data lines from the host |
| bus_d_out | output | 8 | Read data to the host |
| bus_d_oe | output | 1 | Output enable for the data lines |
| busy_flag | input | 1 | Busy flag for status reads |
| addr_cnt | input | 7 | Address counter for status reads |
| rd_byte | input | 8 | Data register contents for data reads |
| cmd_wr | output | 1 | One-cycle instruction write strobe |
| dat_wr | output | 1 | One-cycle data write strobe |
| dat_rd | output | 1 | One-cycle data-register read strobe |
| wr_byte | output | 8 | Byte accompanying a write strobe |
| wide_mode | output | 1 | Current width: 1 = 8-bit, 0 = 4-bit |

## Verification
The assertions take for granted that the host keeps `bus_sel`, `bus_rd` and `bus_d_in` steady from before the strobe rises until several clocks after it falls. They also assume each strobe phase lasts longer than the synchroniser delay, so that every host cycle produces exactly one detected falling edge. The stimulus holds each strobe level for four clocks and changes the control and data lines only while the strobe is low and has settled. Read sources are held constant while a read is in progress.

// File: rtl/lcd_host_port.sv
module lcd_host_port #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_strobe,
  input  logic       bus_sel,
  input  logic       bus_rd,
  input  logic [7:0] bus_d_in,
  output logic [7:0] bus_d_out,
  output logic       bus_d_oe,
  input  logic       busy_flag,
  input  logic [6:0] addr_cnt,
  input  logic [7:0] rd_byte,
  output logic       cmd_wr,
  output logic       dat_wr,
  output logic       dat_rd,
  output logic [7:0] wr_byte,
  output logic       wide_mode
);

  logic [SYNC_STAGES:0] e_pipe;
  logic       e_now, e_prev, fall;
  logic       phase;
  logic [3:0] hi_nib;
  logic [7:0] full_byte, src;
  logic       last_half;

  assign e_now     = e_pipe[SYNC_STAGES-1];
  assign e_prev    = e_pipe[SYNC_STAGES];
  assign fall      = e_prev & ~e_now;
  assign full_byte = wide_mode ? bus_d_in : {hi_nib, bus_d_in[7:4]};
  assign last_half = wide_mode | phase;

  assign src       = bus_sel ? rd_byte : {busy_flag, addr_cnt};
  assign bus_d_oe  = e_now & bus_rd;
  assign bus_d_out = wide_mode ? src :
                     (phase ? {src[3:0], 4'h0} : {src[7:4], 4'h0});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_pipe    <= '0;
      phase     <= 1'b0;
      hi_nib    <= 4'h0;
      wide_mode <= 1'b1;
      cmd_wr    <= 1'b0;
      dat_wr    <= 1'b0;
      dat_rd    <= 1'b0;
      wr_byte   <= 8'h00;
    end else begin
      e_pipe <= {e_pipe[SYNC_STAGES-1:0], bus_strobe};
      cmd_wr <= 1'b0;
      dat_wr <= 1'b0;
      dat_rd <= 1'b0;
      if (fall) begin
        if (!wide_mode) phase <= ~phase;
        if (last_half) begin
          if (!bus_rd) begin
            cmd_wr  <= ~bus_sel;
            dat_wr  <= bus_sel;
            wr_byte <= full_byte;
            if (!bus_sel && full_byte[7:5] == 3'b001 && full_byte[4] != wide_mode) begin
              wide_mode <= full_byte[4];
              phase     <= 1'b0;
            end
          end else if (bus_sel) begin
            dat_rd <= 1'b1;
          end
        end else begin
          hi_nib <= bus_d_in[7:4];
        end
      end
    end
  end

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_wr, dat_wr, dat_rd}));

  // R4
  strobe_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr || dat_wr || dat_rd) |-> $past(fall));

  // R7
  width_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wide_mode) |-> (!phase && $past(fall && !bus_rd && !bus_sel)));

  // R8
  rd_strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_rd |-> $past(bus_rd && bus_sel));

  // R10
  oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_d_oe |-> (bus_rd && e_now));

endmodule

// File: tb/lcd_host_port_tb.sv
module lcd_host_port_tb;
  logic clk = 0, rst_n = 0;
  logic bus_strobe = 0, bus_sel = 0, bus_rd = 0;
  logic [7:0] bus_d_in = 0, bus_d_out, rd_byte = 8'h5E, wr_byte;
  logic bus_d_oe, busy_flag = 1'b1, cmd_wr, dat_wr, dat_rd, wide_mode;
  logic [6:0] addr_cnt = 7'h2B;
  int checks = 0, fails = 0;
  logic [9:0] exp_q[$];
  logic [7:0] got;
  logic got_oe;

  always #5 clk = ~clk;

  lcd_host_port u_dut (.clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_sel(bus_sel),
    .bus_rd(bus_rd), .bus_d_in(bus_d_in), .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe),
    .busy_flag(busy_flag), .addr_cnt(addr_cnt), .rd_byte(rd_byte), .cmd_wr(cmd_wr),
    .dat_wr(dat_wr), .dat_rd(dat_rd), .wr_byte(wr_byte), .wide_mode(wide_mode));

  task automatic chk(string req, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: every internal strobe pops one expected item {kind, byte}
  always @(negedge clk) if (rst_n && (cmd_wr || dat_wr || dat_rd)) begin
    logic [9:0] act;
    act = dat_rd ? {2'd2, 8'h00} : {dat_wr ? 2'd1 : 2'd0, wr_byte};
    if (exp_q.size() == 0) chk("R2/R4/R8 unexpected strobe", act, 10'h3FF);
    else chk("R2/R4/R8 strobe", act, exp_q.pop_front());
  end

  task automatic xfer(input logic s, input logic r, input logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_rd = r; bus_d_in = d;
    @(negedge clk);
    bus_strobe = 1;
    repeat (4) @(negedge clk);
    got = bus_d_out; got_oe = bus_d_oe;
    bus_strobe = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic wr8(input logic s, input logic [7:0] b);
    exp_q.push_back({1'b0, s, b});
    xfer(s, 1'b0, b);
    chk("R10 oe off on write", {9'd0, got_oe}, 10'd0);
  endtask

  task automatic wr4(input logic s, input logic [7:0] b, input logic [3:0] junk);
    xfer(s, 1'b0, {b[7:4], junk});
    exp_q.push_back({1'b0, s, b});
    xfer(s, 1'b0, {b[3:0], ~junk});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 wide_mode", {9'd0, wide_mode}, 10'd1);
    chk("R1 oe", {9'd0, bus_d_oe}, 10'd0);
    chk("R1 strobes", {7'd0, cmd_wr, dat_wr, dat_rd}, 10'd0);

    // R2 8-bit writes
    wr8(0, 8'h01);
    wr8(1, 8'hA5);
    wr8(1, 8'h3C);
    chk("R9 data 0x3C keeps width", {9'd0, wide_mode}, 10'd1);
    wr8(0, 8'h38);
    chk("R9 8-bit function set keeps width", {9'd0, wide_mode}, 10'd1);

    // R3 8-bit reads
    xfer(0, 1, 8'h00);
    chk("R3 status byte", {2'b0, got}, {2'b0, 8'hAB});
    chk("R3 oe on read", {9'd0, got_oe}, 10'd1);
    exp_q.push_back({2'd2, 8'h00});
    xfer(1, 1, 8'h00);
    chk("R3 data byte", {2'b0, got}, {2'b0, 8'h5E});

    // R7 switch to 4-bit
    wr8(0, 8'h28);
    chk("R7 4-bit selected", {9'd0, wide_mode}, 10'd0);

    // R4 R5 4-bit writes with junk on low lines
    wr4(1, 8'hC3, 4'h0);
    wr4(0, 8'h06, 4'hA);
    chk("R9 cmd 0x06 keeps width", {9'd0, wide_mode}, 10'd0);
    wr4(1, 8'h7E, 4'h5);

    // R6 4-bit status read
    xfer(0, 1, 8'h00);
    chk("R6 status high nibble", {6'b0, got[7:4]}, {6'b0, 4'hA});
    xfer(0, 1, 8'h00);
    chk("R6 status low nibble", {6'b0, got[7:4]}, {6'b0, 4'hB});

    // R8 4-bit data read: one read strobe after second nibble
    xfer(1, 1, 8'h00);
    chk("R8 data high nibble", {6'b0, got[7:4]}, {6'b0, 4'h5});
    exp_q.push_back({2'd2, 8'h00});
    xfer(1, 1, 8'h00);
    chk("R8 data low nibble", {6'b0, got[7:4]}, {6'b0, 4'hE});

    // R7 back to 8-bit
    wr4(0, 8'h30, 4'hF);
    chk("R7 8-bit selected", {9'd0, wide_mode}, 10'd1);
    wr8(1, 8'h99);

    repeat (5) @(negedge clk);
    chk("R2/R4/R8 all strobes seen", exp_q.size(), 10'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule